// File: doc/BRIEF.md
# Test-Gated Noise Shift Register

This block holds the 23-bit pseudo-random sequence that drives the noise voice of a sound oscillator. While the test level is low, every noise-clock strobe advances the sequence by one left shift. Bit 0 then takes the XOR of bits 22 and 17. The noise-clock strobe is a one-cycle pulse. It is normally made from a rising edge of bit 19 of the companion phase accumulator. An 8-bit noise sample is taken from a fixed set of spread-out taps.

Raising the test level freezes the sequence and starts a fill timer. Each time the timer expires, the register gains more ones from the bottom up, until it holds all ones. Two timing models are available, chosen by one select bit. When the test level drops, the register takes one special shift in which bit 0 takes the inverse of bit 17.

A three-state machine steers the block. RUN means the test level is low. HOLD_WAIT means the test level is high and the fill timer is counting. HOLD_FULL means the test level is high and the register has saturated. The transitions are:
- RUN to HOLD_WAIT on a test rise (enter_hold).
- HOLD_WAIT to HOLD_FULL when a fill step yields all ones (saturate).
- HOLD_WAIT or HOLD_FULL back to RUN on a test fall (release).

Top module: `noise_lfsr_core`

## Requirements
- R1: While reset is asserted and right after it, the register reads 0x7FFFFE, the state is RUN and the fill timer is idle.
- R2: In RUN with the test level low, a cycle with the strobe high gives next = {old[21:0], old[22] ^ old[17]}.
- R3: In RUN with the test level low and no strobe, the register keeps its value.
- R4: The strobe has no effect in any cycle where the test level is high, including the cycle in which it rises.
- R5: The clock edge that first samples the test level high loads the fill timer. The load value is FILL_START_A when the model select is 0 and FILL_START_B when it is 1. The first fill step happens exactly that many edges later.
- R6: A fill step sets bit 0 to one and then ORs the register with itself shifted left by one, masked to 23 bits.
- R7: After a fill step that does not reach 0x7FFFFF, the timer reloads with FILL_STEP_A or FILL_STEP_B, chosen by the model select at that edge. Once the register reaches 0x7FFFFF, the state is HOLD_FULL and the register stays unchanged.
- R8: The edge that first samples the test level low after it was high gives next = {old[21:0], ~old[17]}. Any strobe in that cycle is ignored.
- R9: noise_o bits 7 down to 0 are register bits 22, 20, 16, 13, 11, 7, 4 and 2.
- R10: A test fall cancels any pending fill. A later rise restarts the count from the full start value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_i | input | 1 | Test level; high freezes and fills the register |
| noise_clk_i | input | 1 | One-cycle strobe that advances the sequence |
| model_sel_i | input | 1 | Timing model: 0 selects model A, 1 selects model B |
| lfsr_o | output | 23 | Current register contents |
| noise_o | output | 8 | Noise sample taken from the register taps |

## Verification
Two pairs of events can land in the same cycle, and each pair is driven on purpose.

The first pair is a test fall and a noise strobe. The bench drives both high on the same edge, both after saturation and after short holds. The register must show exactly one inverted-feedback shift (R8). An all-ones register must therefore return to 0x7FFFFE.

The second pair is a test rise and a strobe, in the same way. The register must stay unchanged while the timer starts (R4, R5).

Random phases also let a fall land on a fill-expiry edge and let the model select change between reloads. A bench reference model, built from the requirements, judges every cycle.

// File: rtl/noise_lfsr_pkg.sv
package noise_lfsr_pkg;

    localparam int unsigned LFSR_W  = 23;
    localparam int unsigned NOISE_W = 8;

    localparam logic [LFSR_W-1:0] LFSR_RST_VAL = 23'h7F_FFFE;
    localparam logic [LFSR_W-1:0] LFSR_ONES    = {LFSR_W{1'b1}};

    // feedback tap positions
    localparam int unsigned FB_HI = 22;
    localparam int unsigned FB_LO = 17;

    // noise_o[i] is driven from lfsr bit TAP_POS[i]
    localparam int unsigned TAP_POS [NOISE_W] = '{2, 4, 7, 11, 13, 16, 20, 22};

    typedef enum logic [1:0] {
        ST_RUN       = 2'd0,
        ST_HOLD_WAIT = 2'd1,
        ST_HOLD_FULL = 2'd2
    } hold_state_e;

    typedef enum logic [1:0] {
        OP_KEEP    = 2'd0,
        OP_CLOCK   = 2'd1,
        OP_RELEASE = 2'd2,
        OP_FILL    = 2'd3
    } lfsr_op_e;

endpackage

// File: rtl/noise_fill_timer.sv
module noise_fill_timer #(
    parameter int unsigned CNT_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             run_i,
    output logic             expire_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (run_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expire_o = run_i && (cnt_q == CNT_W'(1));

    // loaded value is visible one edge later
    assert_timer_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !clr_i) |=> (cnt_q == $past(load_val_i)));

    // steady count-down between reloads
    assert_timer_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !load_i && !clr_i && (cnt_q > CNT_W'(1))) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    // a release leaves the timer idle
    assert_timer_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/noise_shift_datapath.sv
module noise_shift_datapath
    import noise_lfsr_pkg::*;
(
    input  lfsr_op_e          op_i,
    input  logic [LFSR_W-1:0] lfsr_i,
    output logic [LFSR_W-1:0] lfsr_nxt_o
);

    logic [LFSR_W-1:0] seeded;

    always_comb begin
        seeded = lfsr_i | LFSR_W'(1);
        unique case (op_i)
            OP_KEEP:    lfsr_nxt_o = lfsr_i;
            OP_CLOCK:   lfsr_nxt_o = {lfsr_i[LFSR_W-2:0], lfsr_i[FB_HI] ^ lfsr_i[FB_LO]};
            OP_RELEASE: lfsr_nxt_o = {lfsr_i[LFSR_W-2:0], ~lfsr_i[FB_LO]};
            OP_FILL:    lfsr_nxt_o = seeded | {seeded[LFSR_W-2:0], 1'b0};
            default:    lfsr_nxt_o = lfsr_i;
        endcase
    end

endmodule

// File: rtl/noise_tap_select.sv
module noise_tap_select
    import noise_lfsr_pkg::*;
(
    input  logic [LFSR_W-1:0]  lfsr_i,
    output logic [NOISE_W-1:0] noise_o
);

    for (genvar g = 0; g < NOISE_W; g++) begin : g_tap
        assign noise_o[g] = lfsr_i[TAP_POS[g]];
    end

endmodule

// File: rtl/noise_lfsr_core.sv
module noise_lfsr_core
    import noise_lfsr_pkg::*;
#(
    parameter int unsigned FILL_START_A = 9768,
    parameter int unsigned FILL_STEP_A  = 1000,
    parameter int unsigned FILL_START_B = 2519864,
    parameter int unsigned FILL_STEP_B  = 315000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               test_i,
    input  logic               noise_clk_i,
    input  logic               model_sel_i,
    output logic [LFSR_W-1:0]  lfsr_o,
    output logic [NOISE_W-1:0] noise_o
);

    localparam int unsigned MAX_AB  = (FILL_START_A > FILL_STEP_A) ? FILL_START_A : FILL_STEP_A;
    localparam int unsigned MAX_CD  = (FILL_START_B > FILL_STEP_B) ? FILL_START_B : FILL_STEP_B;
    localparam int unsigned MAX_ALL = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int unsigned TMR_W   = $clog2(MAX_ALL + 1);

    hold_state_e       state_q, state_d;
    lfsr_op_e          op;
    logic [LFSR_W-1:0] lfsr_q, lfsr_nxt;
    logic              enter_hold, release_hold;
    logic              fill_expire;
    logic              tmr_load, tmr_clr, tmr_run;
    logic [TMR_W-1:0]  tmr_val;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // transition and operation decode
    always_comb begin
        enter_hold   = 1'b0;
        release_hold = 1'b0;
        op           = OP_KEEP;
        state_d      = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (test_i) begin
                    enter_hold = 1'b1;
                    state_d    = ST_HOLD_WAIT;
                end else if (noise_clk_i) begin
                    op = OP_CLOCK;
                end
            end
            ST_HOLD_WAIT: begin
                if (!test_i) begin
                    release_hold = 1'b1;
                    op           = OP_RELEASE;
                    state_d      = ST_RUN;
                end else if (fill_expire) begin
                    op = OP_FILL;
                    if (lfsr_nxt == LFSR_ONES) begin
                        state_d = ST_HOLD_FULL;
                    end
                end
            end
            ST_HOLD_FULL: begin
                if (!test_i) begin
                    release_hold = 1'b1;
                    op           = OP_RELEASE;
                    state_d      = ST_RUN;
                end
            end
            default: begin
                state_d = ST_RUN;
            end
        endcase
    end

    // fill timer control
    always_comb begin
        tmr_clr  = release_hold;
        tmr_run  = (state_q == ST_HOLD_WAIT) && test_i;
        tmr_load = enter_hold || (fill_expire && test_i && (lfsr_nxt != LFSR_ONES));
        if (enter_hold) begin
            tmr_val = model_sel_i ? TMR_W'(FILL_START_B) : TMR_W'(FILL_START_A);
        end else begin
            tmr_val = model_sel_i ? TMR_W'(FILL_STEP_B) : TMR_W'(FILL_STEP_A);
        end
    end

    noise_fill_timer #(
        .CNT_W (TMR_W)
    ) i_fill_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (tmr_clr),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .run_i      (tmr_run),
        .expire_o   (fill_expire)
    );

    noise_shift_datapath i_datapath (
        .op_i       (op),
        .lfsr_i     (lfsr_q),
        .lfsr_nxt_o (lfsr_nxt)
    );

    // shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_q <= LFSR_RST_VAL;
        end else begin
            lfsr_q <= lfsr_nxt;
        end
    end

    noise_tap_select i_taps (
        .lfsr_i  (lfsr_q),
        .noise_o (noise_o)
    );

    assign lfsr_o = lfsr_q;

    // idle in RUN keeps the value
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !test_i && !noise_clk_i) |=> $stable(lfsr_q));

    // normal feedback shift
    assert_clock_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !test_i && noise_clk_i) |=>
        (lfsr_q == {$past(lfsr_q[LFSR_W-2:0]), $past(lfsr_q[FB_HI]) ^ $past(lfsr_q[FB_LO])}));

    // strobes ignored while test is high and no fill is due
    assert_strobe_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (test_i && !fill_expire) |=> $stable(lfsr_q));

    // fill only adds ones and always sets bit 0
    assert_fill_grows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_expire && test_i) |=> (((lfsr_q & $past(lfsr_q)) == $past(lfsr_q)) && lfsr_q[0]));

    // saturated state holds all ones
    assert_full_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD_FULL) |-> (lfsr_q == LFSR_ONES));

    // release shift with inverted feedback
    assert_release_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN && !test_i) |=>
        (lfsr_q == {$past(lfsr_q[LFSR_W-2:0]), ~$past(lfsr_q[FB_LO])}));

    // tap extremes of the noise sample
    assert_taps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (noise_o[NOISE_W-1] == lfsr_q[LFSR_W-1]) && (noise_o[0] == lfsr_q[2]));

endmodule

// File: tb/test_noise_lfsr_core.sv
module test_noise_lfsr_core;

    localparam int unsigned SA = 40;
    localparam int unsigned TA = 7;
    localparam int unsigned SB = 90;
    localparam int unsigned TB = 13;
    localparam logic [22:0] ONES = 23'h7F_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        test_i = 1'b0;
    logic        noise_clk_i = 1'b0;
    logic        model_sel_i = 1'b0;
    logic [22:0] lfsr_o;
    logic [7:0]  noise_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // reference state
    logic [22:0] ref_lfsr;
    bit          ref_hold;
    int          ref_cnt;

    always #10 clk = ~clk;

    noise_lfsr_core #(
        .FILL_START_A (SA),
        .FILL_STEP_A  (TA),
        .FILL_START_B (SB),
        .FILL_STEP_B  (TB)
    ) i_noise_lfsr_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .test_i      (test_i),
        .noise_clk_i (noise_clk_i),
        .model_sel_i (model_sel_i),
        .lfsr_o      (lfsr_o),
        .noise_o     (noise_o)
    );

    function automatic logic [7:0] taps(input logic [22:0] r);
        return {r[22], r[20], r[16], r[13], r[11], r[7], r[4], r[2]};
    endfunction

    function automatic logic [22:0] fill_step(input logic [22:0] r);
        logic [22:0] t;
        t = r | 23'd1;
        return t | {t[21:0], 1'b0};
    endfunction

    task automatic check(input string tag, input logic [22:0] got, input logic [22:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // one edge of the reference model, written from the requirements
    task automatic ref_step(input logic t, input logic s, input logic m, output string tag);
        if (!ref_hold) begin
            if (t) begin
                ref_hold = 1'b1;
                ref_cnt  = m ? SB : SA;
                tag = "R5";
            end else if (s) begin
                ref_lfsr = {ref_lfsr[21:0], ref_lfsr[22] ^ ref_lfsr[17]};
                tag = "R2";
            end else begin
                tag = "R3";
            end
        end else if (!t) begin
            ref_lfsr = {ref_lfsr[21:0], ~ref_lfsr[17]};
            ref_hold = 1'b0;
            ref_cnt  = 0;
            tag = "R8";
        end else if (ref_cnt > 0) begin
            ref_cnt--;
            if (ref_cnt == 0) begin
                ref_lfsr = fill_step(ref_lfsr);
                if (ref_lfsr != ONES) ref_cnt = m ? TB : TA;
                tag = "R6";
            end else begin
                tag = "R4";
            end
        end else begin
            tag = "R7";
        end
    endtask

    task automatic tick(input logic t, input logic s, input logic m);
        string tag;
        test_i = t;
        noise_clk_i = s;
        model_sel_i = m;
        @(posedge clk);
        ref_step(t, s, m, tag);
        @(negedge clk);
        check(tag, lfsr_o, ref_lfsr);
        check({tag, " R9"}, {15'd0, noise_o}, {15'd0, taps(ref_lfsr)});
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd2718);
        ref_lfsr = 23'h7F_FFFE;
        ref_hold = 1'b0;
        ref_cnt  = 0;

        // R1: reset value, during and after reset
        repeat (3) @(negedge clk);
        check("R1", lfsr_o, 23'h7F_FFFE);
        check("R9", {15'd0, noise_o}, {15'd0, taps(23'h7F_FFFE)});
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", lfsr_o, 23'h7F_FFFE);

        // R2 / R3 directed
        repeat (20) tick(1'b0, 1'b1, 1'b0);
        repeat (10) tick(1'b0, 1'b0, 1'b0);

        // R4..R7 model A: hold with strobes until saturation
        for (int i = 0; i < 400; i++) tick(1'b1, 1'($urandom_range(0, 1)), 1'b0);
        check("R7", lfsr_o, ONES);
        // R8: fall coincident with a strobe
        tick(1'b0, 1'b1, 1'b0);
        check("R8", lfsr_o, 23'h7F_FFFE);

        // model B hold, rise coincident with a strobe
        for (int i = 0; i < 700; i++) tick(1'b1, 1'b1, 1'b1);
        check("R7", lfsr_o, ONES);
        tick(1'b0, 1'b1, 1'b1);

        // R10: cancel before expiry, then restart
        repeat (5) tick(1'b0, 1'b1, 1'b0);
        repeat (20) tick(1'b1, 1'b0, 1'b0);
        repeat (3) tick(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 45; i++) tick(1'b1, 1'b0, 1'b0);
        tick(1'b0, 1'b1, 1'b0);

        // single-cycle test pulse with strobes
        tick(1'b1, 1'b1, 1'b0);
        tick(1'b0, 1'b1, 1'b0);

        // random mix
        for (int i = 0; i < 20000; i++) begin
            logic t;
            t = test_i;
            if ($urandom_range(0, 63) == 0) t = ~t;
            tick(t, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end
        tick(1'b0, 1'b0, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule